// File: doc/BRIEF.md
# Gated Edge Counter With Timestamped Count Reports

This block counts transitions of an asynchronous digital input. A configuration write selects which transitions count: rising, falling, both or none. The same write can also request a report, clear the count, or do both. A request does not produce one event per edge. It produces a single result that holds the count and the timestamp of the request. The counter keeps running while results wait in a short ordered queue behind a valid/ready port.

A typical gate period has three steps. A write enables the wanted polarity and clears the count. The gate then stays open. A later write disables counting and asks for a report, and that request usually marks the gate-closing time. Several gate periods may be requested before any result is read. The results then leave in the order they were requested. The count saturates at all-ones, so a reader can tell that it may have overflowed.

Top module: `gated_edge_counter`

## Requirements
- R1: After reset, resValid is low, both edge enables are off and the count is zero, so a report requested before any edge carries count 0.
- R2: The input passes through a two-flop synchroniser. An edge is found by comparing the newest synchronised sample with the one before it. Each enabled edge adds exactly one to the count, and enabling both polarities counts every transition.
- R3: A config write replaces both edge enables on the clock edge that samples it. An edge of a disabled polarity leaves the count unchanged.
- R4: A config write with cfgSendEvent set queues exactly one result on the next clock edge, so resValid is high from the second edge after the write.
- R5: resStamp of a result equals timeNow as sampled on the clock edge of the requesting config write. It is not the time of any counted edge.
- R6: A config write with cfgClearCount set clears the count once, on the next clock edge. An edge that would have counted on that same edge is discarded.
- R7: A write with both cfgSendEvent and cfgClearCount set reports the count from before the clear, then clears it.
- R8: The count stops at 2^CNT_W-1 and does not wrap. It stays there until a clear.
- R9: Up to DEPTH results wait in request order. The result at the output stays stable while resValid is high and resReady is low, and it leaves on a clock edge where both are high.
- R10: Edges keep counting while results wait in the queue or are being read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sigIn | input | 1 | Asynchronous input whose transitions are counted |
| cfgValid | input | 1 | Config write strobe, one cycle |
| cfgCountRise | input | 1 | Count rising edges |
| cfgCountFall | input | 1 | Count falling edges |
| cfgSendEvent | input | 1 | Request one count report |
| cfgClearCount | input | 1 | Clear the count once |
| timeNow | input | TS_W | Free-running timestamp counter, used as-is |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Consumer accepts result |
| resCount | output | CNT_W | Reported count |
| resStamp | output | TS_W | Timestamp of the requesting config write |

## Verification
The assertions assume the requester never has more than DEPTH reports outstanding. Outstanding reports are those already queued plus the one still pending. A request made while the queue is full would be lost. The bench keeps a reference queue and a pending-report flag, and it only sets cfgSendEvent when their sum is below DEPTH. The assertions also assume timeNow and the config flags change only between clock edges, and the bench drives them on the falling edge.

// File: rtl/gec_pkg.sv
package gec_pkg;
  // Strobes from control to the counting datapath
  typedef struct packed {
    logic countRise;
    logic countFall;
    logic clearNow;
  } gec_strobe_t;
endpackage

// File: rtl/gec_ctrl.sv
module gec_ctrl
  import gec_pkg::*;
#(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfgValid,
  input  logic            cfgCountRise,
  input  logic            cfgCountFall,
  input  logic            cfgSendEvent,
  input  logic            cfgClearCount,
  input  logic [TS_W-1:0] timeNow,
  output gec_strobe_t     strobe,
  output logic            pushReq,
  output logic [TS_W-1:0] reqStamp
);
  logic enRise, enFall, sendPend, clearPend;
  logic [TS_W-1:0] stampReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enRise    <= 1'b0;
      enFall    <= 1'b0;
      sendPend  <= 1'b0;
      clearPend <= 1'b0;
      stampReg  <= '0;
    end else begin
      sendPend  <= cfgValid && cfgSendEvent;
      clearPend <= cfgValid && cfgClearCount;
      if (cfgValid) begin
        enRise <= cfgCountRise;
        enFall <= cfgCountFall;
      end
      if (cfgValid && cfgSendEvent) stampReg <= timeNow;
    end
  end

  always_comb begin
    strobe.countRise = enRise;
    strobe.countFall = enFall;
    strobe.clearNow  = clearPend;
  end

  assign pushReq  = sendPend;
  assign reqStamp = stampReg;
endmodule

// File: rtl/gec_datapath.sv
module gec_datapath
  import gec_pkg::*;
#(
  parameter int CNT_W       = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sigIn,
  input  gec_strobe_t      strobe,
  output logic [CNT_W-1:0] countVal
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int SMSB = SYNC_STAGES - 1;

  logic [SMSB:0] syncChain;
  logic          prevSample;
  logic          riseSeen, fallSeen, hit;
  logic [CNT_W-1:0] countReg;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) syncChain <= '0;
        else        syncChain <= sigIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rst_n) syncChain <= '0;
        else        syncChain <= {syncChain[SMSB-1:0], sigIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prevSample <= 1'b0;
    else        prevSample <= syncChain[SMSB];
  end

  always_comb begin
    riseSeen = syncChain[SMSB] & ~prevSample;
    fallSeen = ~syncChain[SMSB] & prevSample;
    hit      = (riseSeen & strobe.countRise) | (fallSeen & strobe.countFall);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           countReg <= '0;
    else if (strobe.clearNow)             countReg <= '0;
    else if (hit && countReg != CNT_MAX)  countReg <= countReg + 1'b1;
  end

  assign countVal = countReg;
endmodule

// File: rtl/gec_result_queue.sv
module gec_result_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         popReady,
  output logic         headValid,
  output logic [W-1:0] headData,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] used;
  logic doPush, doPop;

  assign headValid = (used != '0);
  assign full      = (used == FULL_N);
  assign doPop     = headValid && popReady;
  assign doPush    = push && !full;
  assign headData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
      used  <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end
endmodule

// File: rtl/gated_edge_counter.sv
module gated_edge_counter
  import gec_pkg::*;
#(
  parameter int CNT_W       = 31,
  parameter int TS_W        = 64,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sigIn,
  input  logic             cfgValid,
  input  logic             cfgCountRise,
  input  logic             cfgCountFall,
  input  logic             cfgSendEvent,
  input  logic             cfgClearCount,
  input  logic [TS_W-1:0]  timeNow,
  output logic             resValid,
  input  logic             resReady,
  output logic [CNT_W-1:0] resCount,
  output logic [TS_W-1:0]  resStamp
);
  localparam int ENT_W = CNT_W + TS_W;

  gec_strobe_t      strobe;
  logic             pushReq;
  logic [TS_W-1:0]  reqStamp;
  logic [CNT_W-1:0] countVal;
  logic [ENT_W-1:0] headEntry;
  logic             qFull;

  gec_ctrl #(.TS_W(TS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgValid(cfgValid),
    .cfgCountRise(cfgCountRise), .cfgCountFall(cfgCountFall),
    .cfgSendEvent(cfgSendEvent), .cfgClearCount(cfgClearCount),
    .timeNow(timeNow), .strobe(strobe), .pushReq(pushReq), .reqStamp(reqStamp)
  );

  gec_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .sigIn(sigIn), .strobe(strobe), .countVal(countVal)
  );

  gec_result_queue #(.W(ENT_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(pushReq), .pushData({countVal, reqStamp}),
    .popReady(resReady), .headValid(resValid), .headData(headEntry), .full(qFull)
  );

  assign resCount = headEntry[ENT_W-1:TS_W];
  assign resStamp = headEntry[TS_W-1:0];
endmodule

// File: rtl/gec_checker.sv
module gec_checker #(
  parameter int CNT_W = 31,
  parameter int TS_W  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfgValid,
  input logic             cfgSendEvent,
  input logic             resValid,
  input logic             resReady,
  input logic [CNT_W-1:0] resCount,
  input logic [TS_W-1:0]  resStamp,
  input logic [CNT_W-1:0] countVal,
  input logic             clearNow,
  input logic             pushReq,
  input logic             qFull
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_report_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgValid && cfgSendEvent) |-> ##2 resValid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !resReady) |=> (resValid && $stable(resCount) && $stable(resStamp)));

  assert_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pushReq |-> !qFull);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clearNow |=> (countVal == '0));

  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (countVal == CMAX && !clearNow) |=> (countVal == CMAX));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clearNow |=> (countVal == $past(countVal) || countVal == $past(countVal) + 1'b1));
endmodule

bind gated_edge_counter gec_checker #(.CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfgValid(cfgValid), .cfgSendEvent(cfgSendEvent),
  .resValid(resValid), .resReady(resReady), .resCount(resCount), .resStamp(resStamp),
  .countVal(countVal), .clearNow(strobe.clearNow), .pushReq(pushReq), .qFull(qFull)
);

// File: tb/sim_gated_edge_counter.sv
`timescale 1ns/1ps
module sim_gated_edge_counter;
  localparam int CW = 6;
  localparam int TW = 16;
  localparam int DP = 4;
  localparam int BMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sigIn = 1'b0;
  logic cfgValid = 1'b0, cfgCountRise = 1'b0, cfgCountFall = 1'b0;
  logic cfgSendEvent = 1'b0, cfgClearCount = 1'b0;
  logic [TW-1:0] timeNow = '0;
  logic resValid, resReady = 1'b0;
  logic [CW-1:0] resCount;
  logic [TW-1:0] resStamp;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) timeNow <= timeNow + 1'b1;

  gated_edge_counter #(.CNT_W(CW), .TS_W(TW), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .sigIn(sigIn), .cfgValid(cfgValid),
    .cfgCountRise(cfgCountRise), .cfgCountFall(cfgCountFall),
    .cfgSendEvent(cfgSendEvent), .cfgClearCount(cfgClearCount),
    .timeNow(timeNow), .resValid(resValid), .resReady(resReady),
    .resCount(resCount), .resStamp(resStamp)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements
  logic m1 = 0, m2 = 0, m3 = 0, mEnR = 0, mEnF = 0, mSend = 0, mClr = 0;
  int mCnt = 0;
  logic [TW-1:0] mStamp = '0;
  int qCnt [64];
  logic [TW-1:0] qStp [64];
  int qHead = 0, qSize = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 <= 0; m2 <= 0; m3 <= 0; mEnR <= 0; mEnF <= 0;
      mSend <= 0; mClr <= 0; mCnt <= 0; qHead = 0; qSize = 0;
    end else begin
      bit hitNow;
      hitNow = ((m2 & ~m3) & mEnR) | ((~m2 & m3) & mEnF);
      check(resValid == (qSize != 0), "R4 valid", resValid, qSize != 0);
      if (resValid && resReady && qSize != 0) begin
        check(resCount == qCnt[qHead], "R9 order count", resCount, qCnt[qHead]);
        check(resStamp == qStp[qHead], "R5 stamp", resStamp, qStp[qHead]);
        qHead = (qHead + 1) % 64;
        qSize = qSize - 1;
      end
      if (mSend) begin
        qCnt[(qHead + qSize) % 64] = mCnt;
        qStp[(qHead + qSize) % 64] = mStamp;
        qSize = qSize + 1;
      end
      m1 <= sigIn; m2 <= m1; m3 <= m2;
      if (cfgValid) begin
        mEnR <= cfgCountRise; mEnF <= cfgCountFall;
        if (cfgSendEvent) mStamp <= timeNow;
      end
      mSend <= cfgValid && cfgSendEvent;
      mClr  <= cfgValid && cfgClearCount;
      if (mClr) mCnt <= 0;
      else if (hitNow && mCnt != BMAX) mCnt <= mCnt + 1;
    end
  end

  logic [TW-1:0] lastStamp;

  task automatic cfg(input bit r, input bit f, input bit s, input bit c);
    @(negedge clk);
    cfgValid = 1; cfgCountRise = r; cfgCountFall = f;
    cfgSendEvent = s; cfgClearCount = c;
    lastStamp = timeNow;
    @(negedge clk);
    cfgValid = 0; cfgSendEvent = 0; cfgClearCount = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sigIn = 1; repeat (3) @(negedge clk);
      sigIn = 0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic getResult(output int cnt, output logic [TW-1:0] stp);
    int guard = 0;
    while (!resValid && guard < 50) begin @(negedge clk); guard++; end
    cnt = resCount; stp = resStamp;
    resReady = 1;
    @(negedge clk);
    resReady = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c;
    logic [TW-1:0] st, s1;
    int h0, h1;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(resValid == 0, "R1 reset valid", resValid, 0);
    cfg(0, 0, 1, 0);
    getResult(c, st);
    check(c == 0, "R1 reset count", c, 0);

    // R2/R5: rising only
    cfg(1, 0, 0, 1); pulses(5); cfg(0, 0, 1, 0); s1 = lastStamp;
    getResult(c, st);
    check(c == 5, "R2 rising only", c, 5);
    check(st == s1, "R5 request stamp", st, s1);
    // falling only
    cfg(0, 1, 0, 1); pulses(3); cfg(0, 0, 1, 0);
    getResult(c, st);
    check(c == 3, "R2 falling only", c, 3);
    // both
    cfg(1, 1, 0, 1); pulses(4); cfg(0, 0, 1, 0);
    getResult(c, st);
    check(c == 8, "R2 both polarities", c, 8);
    // R3: none enabled
    cfg(0, 0, 0, 1); pulses(3); cfg(0, 0, 1, 0);
    getResult(c, st);
    check(c == 0, "R3 disabled polarities", c, 0);
    // R7 / R6: send+clear then send
    cfg(1, 0, 0, 1); pulses(2);
    cfg(1, 0, 1, 1); cfg(1, 0, 1, 0);
    getResult(c, st);
    check(c == 2, "R7 report before clear", c, 2);
    getResult(c, st);
    check(c == 0, "R6 cleared once", c, 0);
    // R6: clear mid-gate keeps only later edges
    cfg(1, 0, 0, 0); pulses(2); cfg(1, 0, 0, 1); pulses(3); cfg(0, 0, 1, 0);
    getResult(c, st);
    check(c == 3, "R6 clear mid gate", c, 3);
    // R9 / R10: queue three, hold, read in order
    cfg(1, 0, 0, 1);
    pulses(1); cfg(1, 0, 1, 0);
    pulses(1); cfg(1, 0, 1, 0);
    pulses(1); cfg(1, 0, 1, 0);
    repeat (2) @(negedge clk);
    h0 = resCount; repeat (3) @(negedge clk); h1 = resCount;
    check(resValid && h0 == h1, "R9 hold while not ready", h1, h0);
    for (int k = 1; k <= 3; k++) begin
      getResult(c, st);
      check(c == k, "R10 counting while queued", c, k);
    end
    // R8: saturation
    cfg(1, 1, 0, 1); pulses(40); cfg(0, 0, 1, 0);
    getResult(c, st);
    check(c == BMAX, "R8 saturation", c, BMAX);

    // Random phase, checked against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      cfgValid = 0; cfgSendEvent = 0; cfgClearCount = 0;
      if ($urandom % 3 == 0) sigIn = ~sigIn;
      resReady = $urandom % 2;
      if ($urandom % 8 == 0) begin
        cfgValid = 1;
        cfgCountRise = $urandom % 2; cfgCountFall = $urandom % 2;
        cfgClearCount = ($urandom % 4 == 0);
        cfgSendEvent = ($urandom % 2) && (qSize + int'(mSend) < DP);
      end
    end
    @(negedge clk);
    cfgValid = 0; cfgSendEvent = 0; cfgClearCount = 0;
    resReady = 1;
    repeat (10) @(negedge clk);
    check(qSize == 0 && !resValid, "R9 drained", qSize, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule